// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles every control-transfer instruction of a 64-bit RISC pipeline in a single registered stage. For each valid instruction it receives the 32-bit instruction word, the address of that instruction, and one 64-bit register operand. For a conditional branch the operand is the register under test. For a jump it is the base register that supplies the target. One clock edge later it reports three things: whether control moves, the address to fetch next, and the return address to store in the register named by the instruction's Ra field, together with a write strobe.

Conditional branches can test the lowest bit of the operand. They can also compare the operand as a signed 64-bit number against zero. Their target is relative to the following instruction, using a signed word displacement. Unconditional branches always move and record the return address. Jumps take their destination from the operand and keep a link as well. The low 16 bits of a jump are hint bits and play no part in the result. Any other opcode falls through to the next sequential address.

Top module: `bru_top`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `taken_o` and `link_we_o` are 0.
- R2: Results appear exactly one clock after the instruction is presented: `valid_o` follows `valid_i` by one cycle, and whenever `valid_o` is 0, `taken_o` and `link_we_o` are 0 too.
- R3: A taken branch (opcodes 0x30 and 0x34, and 0x38 to 0x3F) sets `next_pc_o` to PC + 4 + 4 × D mod 2^64. Here D is instruction bits [20:0] read as a two's-complement number. This holds for both positive and negative D.
- R4: The low-bit tests look at bit 0 of the operand. Opcode 0x38 is taken when bit 0 is 0, and opcode 0x3C is taken when bit 0 is 1.
- R5: The signed tests compare the operand, taken as a signed 64-bit number, against zero. Opcode 0x39 is taken when it equals zero, 0x3D when it is not zero, 0x3A when it is below zero, 0x3B when it is at or below zero, 0x3E when it is at or above zero, and 0x3F when it is above zero.
- R6: Opcodes 0x30 and 0x34 are always taken and behave the same way. `link_o` is PC + 4, and `link_we_o` is 1 unless Ra is 31.
- R7: Opcode 0x1A is a jump. It is always taken, and `next_pc_o` is the operand with bits [1:0] cleared. Instruction bits [15:0] have no effect on any output. The link behaves as in R6.
- R8: `link_idx_o` carries instruction bits [25:21]. `link_we_o` is never 1 when that index is 31.
- R9: When the instruction is not taken, including any opcode not listed above, `next_pc_o` is PC + 4, `taken_o` is 0 and `link_we_o` is 0.
- R10: Conditional branches (0x38 to 0x3F) never raise `link_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction inputs are meaningful this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| opnd_i | input | 64 | Tested register value, or jump base register |
| valid_o | output | 1 | Result valid (one cycle after valid_i) |
| taken_o | output | 1 | Control transfer happens |
| next_pc_o | output | 64 | Address of the next instruction to fetch |
| link_o | output | 64 | Return address (PC + 4) |
| link_we_o | output | 1 | Write link_o into register link_idx_o |
| link_idx_o | output | 5 | Destination register for the link |

## Verification
Some properties are checked on every cycle: the one-cycle latency and the quiet outputs when idle, fall-through to PC + 4, jump targets being word aligned, unconditional transfers always moving with the correct link, conditional branches never linking, and no link write to register 31. Other behaviour can only be shown by the bench's reference model. That includes the sign and scaling of relative targets at both ends of the displacement range, the truth table of all eight conditions, including zero and the most negative operand, and the fact that jump hint bits change nothing.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_COND   = 2'd1,
    CLS_UNCOND = 2'd2,
    CLS_JUMP   = 2'd3
  } xfer_cls_e;

  typedef enum logic [2:0] {
    CC_LOW_CLR = 3'd0,
    CC_ZERO    = 3'd1,
    CC_NEG     = 3'd2,
    CC_NONPOS  = 3'd3,
    CC_LOW_SET = 3'd4,
    CC_NONZERO = 3'd5,
    CC_NONNEG  = 3'd6,
    CC_POS     = 3'd7
  } cond_e;

  localparam int OPC_W = 6;
  localparam int IDX_W = 5;

  localparam logic [OPC_W-1:0] OPC_JUMP   = 6'h1A;
  localparam logic [OPC_W-1:0] OPC_BR     = 6'h30;
  localparam logic [OPC_W-1:0] OPC_BR_SUB = 6'h34;
  localparam logic [2:0]       OPC_COND_HI = 3'b111;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int ILEN   = 32,
  parameter int DISP_W = 21
) (
  input  logic [ILEN-1:0]   instr,
  output xfer_cls_e         cls,
  output cond_e             cond,
  output logic [IDX_W-1:0]  ra_idx,
  output logic [DISP_W-1:0] disp
);

  localparam int OPC_LSB = ILEN - OPC_W;
  localparam int RA_LSB  = OPC_LSB - IDX_W;

  logic [OPC_W-1:0] opc;

  assign opc    = instr[ILEN-1:OPC_LSB];
  assign ra_idx = instr[RA_LSB +: IDX_W];
  assign disp   = instr[DISP_W-1:0];

  always_comb begin
    cls  = CLS_NONE;
    cond = cond_e'(opc[2:0]);
    if (opc[OPC_W-1:OPC_W-3] == OPC_COND_HI) begin
      cls = CLS_COND;
    end else if (opc == OPC_BR || opc == OPC_BR_SUB) begin
      cls = CLS_UNCOND;
    end else if (opc == OPC_JUMP) begin
      cls = CLS_JUMP;
    end
  end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cond_e            cond,
  input  logic [XLEN-1:0]  val,
  output logic             hit
);

  function automatic logic eval_cond(cond_e c, logic [XLEN-1:0] v);
    logic is_zero;
    logic is_neg;
    is_zero = (v == '0);
    is_neg  = v[XLEN-1];
    case (c)
      CC_LOW_CLR: return !v[0];
      CC_LOW_SET: return v[0];
      CC_ZERO:    return is_zero;
      CC_NONZERO: return !is_zero;
      CC_NEG:     return is_neg;
      CC_NONPOS:  return is_neg || is_zero;
      CC_NONNEG:  return !is_neg;
      CC_POS:     return !is_neg && !is_zero;
      default:    return 1'b0;
    endcase
  endfunction

  assign hit = eval_cond(cond, val);

endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 21,
  parameter int ILEN_B = 4
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   base,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   rel_pc,
  output logic [XLEN-1:0]   abs_pc
);

  localparam int ALIGN_W = $clog2(ILEN_B);
  localparam int EXT_W   = XLEN - DISP_W - ALIGN_W;

  function automatic logic [XLEN-1:0] scale_disp(logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d, {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] align_base(logic [XLEN-1:0] b);
    return {b[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction

  assign seq_pc = pc + XLEN'(ILEN_B);
  assign rel_pc = seq_pc + scale_disp(disp);
  assign abs_pc = align_base(base);

endmodule

// File: rtl/bru_top.sv
module bru_top
  import bru_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int ILEN     = 32,
  parameter int DISP_W   = 21,
  parameter int ZERO_REG = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [ILEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  opnd_i,
  output logic             valid_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  link_o,
  output logic             link_we_o,
  output logic [4:0]       link_idx_o
);

  localparam int ILEN_B = ILEN / 8;

  xfer_cls_e         cls;
  cond_e             cond;
  logic [IDX_W-1:0]  ra_idx;
  logic [DISP_W-1:0] disp;
  logic              cond_hit;
  logic [XLEN-1:0]   seq_pc, rel_pc, abs_pc;

  // named internal events
  logic              xfer_take;
  logic              link_req;
  logic [XLEN-1:0]   npc_d;

  bru_decode #(.ILEN(ILEN), .DISP_W(DISP_W)) u_dec (
    .instr  (instr_i),
    .cls    (cls),
    .cond   (cond),
    .ra_idx (ra_idx),
    .disp   (disp)
  );

  bru_cond #(.XLEN(XLEN)) u_cond (
    .cond (cond),
    .val  (opnd_i),
    .hit  (cond_hit)
  );

  bru_target #(.XLEN(XLEN), .DISP_W(DISP_W), .ILEN_B(ILEN_B)) u_tgt (
    .pc     (pc_i),
    .disp   (disp),
    .base   (opnd_i),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc),
    .abs_pc (abs_pc)
  );

  always_comb begin
    xfer_take = 1'b0;
    link_req  = 1'b0;
    npc_d     = seq_pc;
    case (cls)
      CLS_COND: begin
        xfer_take = cond_hit;
        if (cond_hit) npc_d = rel_pc;
      end
      CLS_UNCOND: begin
        xfer_take = 1'b1;
        link_req  = 1'b1;
        npc_d     = rel_pc;
      end
      CLS_JUMP: begin
        xfer_take = 1'b1;
        link_req  = 1'b1;
        npc_d     = abs_pc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      next_pc_o  <= '0;
      link_o     <= '0;
      link_idx_o <= '0;
    end else begin
      valid_o    <= valid_i;
      taken_o    <= valid_i && xfer_take;
      link_we_o  <= valid_i && link_req && (ra_idx != IDX_W'(ZERO_REG));
      next_pc_o  <= npc_d;
      link_o     <= seq_pc;
      link_idx_o <= ra_idx;
    end
  end

  // ---------------- assertions ----------------
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!taken_o && !link_we_o));

  a_r8_no_zero_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_idx_o != 5'(ZERO_REG)));

  a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !xfer_take |=> (next_pc_o == $past(pc_i) + XLEN'(ILEN_B)) && !link_we_o);

  a_r7_jump_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cls == CLS_JUMP |=> taken_o && (next_pc_o[1:0] == 2'b00));

  a_r6_uncond_link: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cls == CLS_UNCOND |=> taken_o && (link_o == $past(pc_i) + XLEN'(ILEN_B)));

  a_r10_cond_nolink: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cls == CLS_COND |=> !link_we_o);

endmodule

// File: tb/sim_bru_top.sv
`timescale 1ns/1ps
module sim_bru_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] pc_i = '0;
  logic [63:0] opnd_i = '0;
  logic        valid_o, taken_o, link_we_o;
  logic [63:0] next_pc_o, link_o;
  logic [4:0]  link_idx_o;

  always #2.5 clk = ~clk;

  bru_top u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .opnd_i(opnd_i), .valid_o(valid_o), .taken_o(taken_o),
    .next_pc_o(next_pc_o), .link_o(link_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // expected values queued per presented instruction
  logic        q_valid[$];
  logic        q_taken[$];
  logic        q_we[$];
  logic [63:0] q_npc[$];
  logic [63:0] q_link[$];
  logic [4:0]  q_idx[$];
  string       q_tag[$];
  string       q_wtag[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_br(logic [5:0] op, logic [4:0] ra, int d);
    logic [20:0] df;
    df = 21'(d);
    return {op, ra, df};
  endfunction

  function automatic logic [31:0] mk_jmp(logic [4:0] ra, logic [4:0] rb, logic [15:0] hint);
    return {6'h1A, ra, rb, hint};
  endfunction

  // behavioural reference model
  task automatic model(logic v, logic [31:0] ins, logic [63:0] pc, logic [63:0] x);
    int     op, ra, d;
    longint sx;
    logic   take, link;
    string  tag, wtag;
    logic [63:0] seq, npc;
    op = int'(ins[31:26]);
    ra = int'(ins[25:21]);
    d  = int'(ins[20:0]);
    if (d >= (1 << 20)) d = d - (1 << 21);
    sx = longint'(x);
    seq = pc + 64'd4;
    take = 1'b0; link = 1'b0; tag = "R9"; wtag = "R9";
    case (op)
      'h38: begin take = (x % 2 == 0); tag = "R4"; end
      'h3C: begin take = (x % 2 == 1); tag = "R4"; end
      'h39: begin take = (sx == 0); tag = "R5"; end
      'h3D: begin take = (sx != 0); tag = "R5"; end
      'h3A: begin take = (sx < 0);  tag = "R5"; end
      'h3B: begin take = (sx <= 0); tag = "R5"; end
      'h3E: begin take = (sx >= 0); tag = "R5"; end
      'h3F: begin take = (sx > 0);  tag = "R5"; end
      'h30, 'h34: begin take = 1'b1; link = 1'b1; tag = "R6"; end
      'h1A: begin take = 1'b1; link = 1'b1; tag = "R7"; end
      default: ;
    endcase
    if (op >= 'h38) wtag = "R10";
    else if (link) wtag = (ra == 31) ? "R8" : tag;
    if (!take) tag = "R9";
    if (!take) npc = seq;
    else if (op == 'h1A) npc = (x / 4) * 4;
    else npc = seq + 64'(longint'(d) * 4);
    q_valid.push_back(v);
    q_taken.push_back(v && take);
    q_we.push_back(v && link && ra != 31);
    q_npc.push_back(npc);
    q_link.push_back(seq);
    q_idx.push_back(5'(ra));
    q_tag.push_back((take && op != 'h1A) ? "R3" : tag);
    q_wtag.push_back(wtag);
  endtask

  task automatic compare();
    logic ev;
    ev = q_valid.pop_front();
    chk("R2", "valid_o", 64'(valid_o), 64'(ev));
    if (!ev) begin
      chk("R2", "taken_o idle", 64'(taken_o), 64'd0);
      chk("R2", "link_we_o idle", 64'(link_we_o), 64'd0);
      void'(q_taken.pop_front()); void'(q_we.pop_front());
      void'(q_npc.pop_front()); void'(q_link.pop_front());
      void'(q_idx.pop_front()); void'(q_tag.pop_front()); void'(q_wtag.pop_front());
    end else begin
      string t, w;
      t = q_tag.pop_front();
      w = q_wtag.pop_front();
      chk(t, "taken_o", 64'(taken_o), 64'(q_taken.pop_front()));
      chk(t, "next_pc_o", next_pc_o, q_npc.pop_front());
      chk(w, "link_we_o", 64'(link_we_o), 64'(q_we.pop_front()));
      chk("R6", "link_o", link_o, q_link.pop_front());
      chk("R8", "link_idx_o", 64'(link_idx_o), 64'(q_idx.pop_front()));
    end
  endtask

  // drive at negedge; outputs seen then belong to the previous instruction
  logic primed = 1'b0;
  task automatic step(logic v, logic [31:0] ins, logic [63:0] pc, logic [63:0] x);
    @(negedge clk);
    if (primed) compare();
    valid_i = v; instr_i = ins; pc_i = pc; opnd_i = x;
    model(v, ins, pc, x);
    primed = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] ops[13];
    logic [63:0] vals[8];
    ops = '{6'h38, 6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3E, 6'h3F,
            6'h30, 6'h34, 6'h1A, 6'h00, 6'h11};
    vals = '{64'd0, 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF,
             64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
             64'h0000_1234_5678_9ABF, 64'hFFFF_FFFF_FFFF_FFFE};

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1", "valid_o in reset", 64'(valid_o), 64'd0);
      chk("R1", "taken_o in reset", 64'(taken_o), 64'd0);
      chk("R1", "link_we_o in reset", 64'(link_we_o), 64'd0);
    end
    rst_n = 1'b1;

    // R3 displacements: positive, negative, extremes, PC wrap
    step(1, mk_br(6'h30, 5'd26, 5), 64'h1000, 0);
    step(1, mk_br(6'h34, 5'd26, -5), 64'h1000, 0);
    step(1, mk_br(6'h30, 5'd1, (1 << 20) - 1), 64'h4000_0000, 0);
    step(1, mk_br(6'h30, 5'd1, -(1 << 20)), 64'h4000_0000, 0);
    step(1, mk_br(6'h30, 5'd2, -1), 64'h0, 0);
    step(1, mk_br(6'h34, 5'd2, 0), 64'hFFFF_FFFF_FFFF_FFFC, 0);
    // R8: link suppressed to register 31
    step(1, mk_br(6'h30, 5'd31, 8), 64'h2000, 0);
    step(1, mk_jmp(5'd31, 5'd3, 16'h0000), 64'h2000, 64'h9000);
    // R7: hints ignored, base bits cleared
    step(1, mk_jmp(5'd26, 5'd4, 16'h0000), 64'h3000, 64'h1234_5677);
    step(1, mk_jmp(5'd26, 5'd4, 16'hFFFF), 64'h3000, 64'h1234_5677);
    step(1, mk_jmp(5'd26, 5'd4, 16'h8003), 64'h3000, 64'h1234_5677);
    // R4/R5 every condition against every value
    foreach (vals[i]) begin
      for (int k = 0; k < 8; k++)
        step(1, mk_br(ops[k], 5'd9, -3 + k), 64'h8000 + 64'(i * 64), vals[i]);
    end
    // R2: idle gaps
    step(0, mk_br(6'h30, 5'd5, 4), 64'h100, 0);
    step(0, mk_jmp(5'd5, 5'd1, 16'h0), 64'h100, 64'h500);
    // R9: non-control opcodes
    step(1, {6'h00, 26'h3FF_FFFF}, 64'h5000, 64'h1);
    step(1, {6'h11, 26'h123_4567}, 64'h5004, 64'h0);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ins;
      logic [63:0] x;
      int sel;
      sel = $urandom_range(0, 12);
      ins = {ops[sel], 26'($urandom)};
      case ($urandom_range(0, 3))
        0: x = vals[$urandom_range(0, 7)];
        default: x = {32'($urandom), 32'($urandom)};
      endcase
      step($urandom_range(0, 7) != 0, ins, {32'($urandom), 30'($urandom), 2'b00}, x);
    end
    step(0, 32'h0, 64'h0, 64'h0);
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule